// File: doc/BRIEF.md
# SPI Control and Status Register Slave

This block is an SPI slave that gives a host access to a small file of byte-wide control and status registers. The host lowers chip select and sends one 16-bit frame in SPI mode 0. The frame carries a direction flag, a register address and a data byte. All SPI pins are synchronised into the system clock domain, so all register state lives on one clock.

Reserved bits in each register are either fixed at zero or freely writable, and a per-register write mask enforces this. Frames with a bad shape or a bad target raise sticky error flags in a status register. The same register also latches three error pulses from neighbouring logic and mirrors a live calibration-busy level. A companion register carries one disable bit per flag. Software clears a flag by writing 1 to its bit.

Top module: `spi_regfile`

## Requirements
- R1: A frame is 16 SCLK rising edges while cs_ni is low, with MOSI sampled on each rising edge, MSB first. Bit 15 is the direction (1 = read, 0 = write), bits 14:8 are the address and bits 7:0 are the write data.
- R2: On a read, the addressed register's value is driven on miso_o MSB first. The first bit is driven after the eighth SCLK falling edge and each later bit after the next falling edge. During write frames and while cs_ni is high, miso_o is 0.
- R3: The register map and write masks are as follows. Address 0x00 is fully writable. Address 0x01 has bits 7:4 fixed at 0 and bits 3:0 writable. Address 0x02 has bits 6 and 3 fixed at 0 and all other bits writable. Address 0x04 is fully writable, including its reserved bits 7:6.
- R4: After the asynchronous active-low reset, every register reads 0x00.
- R5: When cs_ni rises after a count of SCLK rising edges other than 16, flag bit 0 of address 0x03 is set and no register is written.
- R6: An access to an address above 0x04 sets flag bit 1 of address 0x03. A read of such an address returns 0x00, and a write to it changes nothing.
- R7: A one-cycle high pulse sets a flag in address 0x03: spi_crc_err_i sets bit 2, mm_crc_err_i sets bit 3 and rom_crc_err_i sets bit 4.
- R8: Flag bits 4:0 are sticky. A write of 1 to a flag bit at address 0x03 clears it, and a write of 0 leaves it unchanged. Bits 7:6 of address 0x03 always read 0.
- R9: While bit k (k = 0..4) of address 0x04 is 1, flag k of address 0x03 cannot be set.
- R10: Bit 5 of address 0x03 reads cal_busy_i, or 0 while bit 5 of address 0x04 is 1. Writes have no effect on this bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | SPI serial clock (mode 0) |
| cs_ni | input | 1 | SPI chip select, active low |
| mosi_i | input | 1 | SPI data from host |
| miso_o | output | 1 | SPI data to host |
| spi_crc_err_i | input | 1 | Error pulse that sets flag bit 2 |
| mm_crc_err_i | input | 1 | Error pulse that sets flag bit 3 |
| rom_crc_err_i | input | 1 | Error pulse that sets flag bit 4 |
| cal_busy_i | input | 1 | Live calibration-busy level |

## Verification
The assertions rely on three properties of the inputs. SCLK is low whenever cs_ni changes. Each SCLK and cs_ni level lasts long enough for the synchroniser and edge detector to see it, which is several system clocks. The error pulses are synchronous to clk_i.

The stimulus holds each SCLK phase and each chip-select gap for ten system clocks. It changes pins only away from the active clock edge. It pulses the status inputs outside of frames, so every edge and every pulse is seen exactly once.

// File: rtl/spi_rf_pkg.sv
package spi_rf_pkg;
  localparam int ADDR_W     = 7;
  localparam int DATA_W     = 8;
  localparam int FRAME_BITS = 16;
  localparam int NUM_CTRL   = 3;
  localparam int NUM_FLAGS  = 5;
  localparam int BUSY_BIT   = NUM_FLAGS;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] data_t;

  localparam addr_t ADDR_FLAGS = addr_t'(NUM_CTRL);
  localparam addr_t ADDR_FDIS  = addr_t'(NUM_CTRL + 1);

  localparam int FLG_LEN = 0;
  localparam int FLG_RW  = 1;

  // writable bits per control register; zero bits are locked reserved
  function automatic data_t ctrl_mask(int idx);
    case (idx)
      0:       return data_t'(8'hFF);
      1:       return data_t'(8'h0F);
      2:       return data_t'(8'hB7);
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/spi_rf_sync.sv
module spi_rf_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  input  logic cs_ni,
  input  logic mosi_i,
  output logic sclk_rise_o,
  output logic sclk_fall_o,
  output logic active_o,
  output logic frame_end_o,
  output logic mosi_o
);
  logic [STAGES-1:0] sclk_q, cs_q, mosi_q;
  logic sclk_d, cs_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= '0;
      mosi_q <= '0;
      cs_q   <= '1;
      sclk_d <= 1'b0;
      cs_d   <= 1'b1;
    end else begin
      sclk_q <= {sclk_q[STAGES-2:0], sclk_i};
      mosi_q <= {mosi_q[STAGES-2:0], mosi_i};
      cs_q   <= {cs_q[STAGES-2:0], cs_ni};
      sclk_d <= sclk_q[STAGES-1];
      cs_d   <= cs_q[STAGES-1];
    end
  end

  assign active_o    = ~cs_q[STAGES-1];
  assign sclk_rise_o = active_o & sclk_q[STAGES-1] & ~sclk_d;
  assign sclk_fall_o = active_o & ~sclk_q[STAGES-1] & sclk_d;
  assign frame_end_o = cs_q[STAGES-1] & ~cs_d;
  assign mosi_o      = mosi_q[STAGES-1];
endmodule

// File: rtl/spi_rf_frame.sv
module spi_rf_frame #(
  parameter int FRAME_BITS = spi_rf_pkg::FRAME_BITS,
  parameter int ADDR_W     = spi_rf_pkg::ADDR_W,
  parameter int DATA_W     = spi_rf_pkg::DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_rise_i,
  input  logic              sclk_fall_i,
  input  logic              frame_end_i,
  input  logic              mosi_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [ADDR_W-1:0] raddr_o,
  output logic              miso_o,
  output logic              frame_ok_o,
  output logic              frame_bad_o,
  output logic              rd_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o
);
  localparam int HDR_BITS = FRAME_BITS - DATA_W;
  localparam int CNT_W    = $clog2(FRAME_BITS + 1) + 1;
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] CNT_HDR  = CNT_W'(HDR_BITS);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;

  logic [FRAME_BITS-1:0] shift_q;
  logic [CNT_W-1:0]      cnt_q;
  logic [DATA_W-1:0]     tx_q;
  logic                  miso_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shift_q <= '0;
      cnt_q   <= '0;
      tx_q    <= '0;
      miso_q  <= 1'b0;
    end else if (frame_end_i) begin
      cnt_q  <= '0;
      tx_q   <= '0;
      miso_q <= 1'b0;
    end else begin
      if (sclk_rise_i) begin
        shift_q <= {shift_q[FRAME_BITS-2:0], mosi_i};
        if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
      end
      if (sclk_fall_i) begin
        if (cnt_q == CNT_HDR) begin
          // header complete: load read data or keep line quiet
          if (shift_q[HDR_BITS-1]) begin
            miso_q <= rdata_i[DATA_W-1];
            tx_q   <= {rdata_i[DATA_W-2:0], 1'b0};
          end else begin
            miso_q <= 1'b0;
            tx_q   <= '0;
          end
        end else if (cnt_q > CNT_HDR) begin
          miso_q <= tx_q[DATA_W-1];
          tx_q   <= {tx_q[DATA_W-2:0], 1'b0};
        end
      end
    end
  end

  assign raddr_o     = shift_q[ADDR_W-1:0];
  assign miso_o      = miso_q;
  assign frame_ok_o  = frame_end_i & (cnt_q == CNT_FULL);
  assign frame_bad_o = frame_end_i & (cnt_q != CNT_FULL);
  assign rd_o        = shift_q[FRAME_BITS-1];
  assign addr_o      = shift_q[FRAME_BITS-2 -: ADDR_W];
  assign wdata_o     = shift_q[DATA_W-1:0];

  // R2
  idle_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_end_i |=> !miso_o);
  // R2
  write_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_fall_i && !frame_end_i && cnt_q == CNT_HDR && !shift_q[HDR_BITS-1]) |=> !miso_o);
endmodule

// File: rtl/spi_rf_regs.sv
module spi_rf_regs
  import spi_rf_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  frame_ok_i,
  input  logic  frame_bad_i,
  input  logic  rd_i,
  input  addr_t addr_i,
  input  data_t wdata_i,
  input  addr_t raddr_i,
  input  logic  spi_crc_err_i,
  input  logic  mm_crc_err_i,
  input  logic  rom_crc_err_i,
  input  logic  cal_busy_i,
  output data_t rdata_o
);
  logic [NUM_CTRL-1:0][DATA_W-1:0] ctrl_q;
  logic [NUM_FLAGS-1:0] flag_q, flag_set, flag_clr;
  data_t fdis_q;
  logic  mapped, wr_en;

  assign mapped = addr_i <= ADDR_FDIS;
  assign wr_en  = frame_ok_i & ~rd_i & mapped;

  always_comb begin
    flag_set          = '0;
    flag_set[FLG_LEN] = frame_bad_i;
    flag_set[FLG_RW]  = frame_ok_i & ~mapped;
    flag_set[2]       = spi_crc_err_i;
    flag_set[3]       = mm_crc_err_i;
    flag_set[4]       = rom_crc_err_i;
    flag_set          = flag_set & ~fdis_q[NUM_FLAGS-1:0];
    flag_clr          = (wr_en && addr_i == ADDR_FLAGS) ? wdata_i[NUM_FLAGS-1:0] : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      flag_q <= '0;
      fdis_q <= '0;
    end else begin
      for (int k = 0; k < NUM_CTRL; k++) begin
        if (wr_en && addr_i == addr_t'(k)) ctrl_q[k] <= wdata_i & ctrl_mask(k);
      end
      if (wr_en && addr_i == ADDR_FDIS) fdis_q <= wdata_i;
      // a new event wins over a same-cycle clear
      flag_q <= (flag_q & ~flag_clr) | flag_set;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int k = 0; k < NUM_CTRL; k++) begin
      if (raddr_i == addr_t'(k)) rdata_o = ctrl_q[k];
    end
    if (raddr_i == ADDR_FLAGS) begin
      rdata_o[NUM_FLAGS-1:0] = flag_q;
      rdata_o[BUSY_BIT]      = cal_busy_i & ~fdis_q[BUSY_BIT];
    end
    if (raddr_i == ADDR_FDIS) rdata_o = fdis_q;
  end

  // R5
  len_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_bad_i && !fdis_q[FLG_LEN]) |=> flag_q[FLG_LEN]);
  // R5
  len_discard_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_bad_i |=> ($stable(ctrl_q) && $stable(fdis_q)));
  // R6
  rw_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_ok_i && !mapped && !fdis_q[FLG_RW]) |=> flag_q[FLG_RW]);
  // R8
  sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q != '0) |=> ((flag_q & $past(flag_q & ~flag_clr)) == $past(flag_q & ~flag_clr)));
endmodule

// File: rtl/spi_regfile.sv
module spi_regfile
  import spi_rf_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  input  logic cs_ni,
  input  logic mosi_i,
  output logic miso_o,
  input  logic spi_crc_err_i,
  input  logic mm_crc_err_i,
  input  logic rom_crc_err_i,
  input  logic cal_busy_i
);
  logic  sclk_rise, sclk_fall, active, frame_end, mosi_s;
  logic  frame_ok, frame_bad, rd;
  addr_t addr, raddr;
  data_t wdata, rdata;

  spi_rf_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i, .rst_ni, .sclk_i, .cs_ni, .mosi_i,
    .sclk_rise_o (sclk_rise),
    .sclk_fall_o (sclk_fall),
    .active_o    (active),
    .frame_end_o (frame_end),
    .mosi_o      (mosi_s)
  );

  spi_rf_frame i_frame (
    .clk_i, .rst_ni,
    .sclk_rise_i (sclk_rise),
    .sclk_fall_i (sclk_fall),
    .frame_end_i (frame_end),
    .mosi_i      (mosi_s),
    .rdata_i     (rdata),
    .raddr_o     (raddr),
    .miso_o,
    .frame_ok_o  (frame_ok),
    .frame_bad_o (frame_bad),
    .rd_o        (rd),
    .addr_o      (addr),
    .wdata_o     (wdata)
  );

  spi_rf_regs i_regs (
    .clk_i, .rst_ni,
    .frame_ok_i  (frame_ok),
    .frame_bad_i (frame_bad),
    .rd_i        (rd),
    .addr_i      (addr),
    .wdata_i     (wdata),
    .raddr_i     (raddr),
    .spi_crc_err_i, .mm_crc_err_i, .rom_crc_err_i, .cal_busy_i,
    .rdata_o     (rdata)
  );

  // R2
  cs_high_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active && $past(!active)) |-> !miso_o);
endmodule

// File: tb/test_spi_regfile.sv
`timescale 1ns/1ps
module test_spi_regfile;
  localparam int HP = 100;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso;
  logic crc_p = 1'b0, mm_p = 1'b0, rom_p = 1'b0, busy = 1'b0;
  int checks = 0, fails = 0;
  bit finished = 1'b0;

  // reference model
  logic [7:0] m_ctrl [3];
  logic [4:0] m_flag;
  logic [7:0] m_dis;

  always #5 clk = ~clk;

  spi_regfile i_spi_regfile (
    .clk_i(clk), .rst_ni(rst_ni), .sclk_i(sclk), .cs_ni(cs_n), .mosi_i(mosi),
    .miso_o(miso), .spi_crc_err_i(crc_p), .mm_crc_err_i(mm_p),
    .rom_crc_err_i(rom_p), .cal_busy_i(busy)
  );

  task automatic check8(string req, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%02h expected=%02h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] m_view(int a);
    if (a < 3) return m_ctrl[a];
    if (a == 3) return {2'b00, busy & ~m_dis[5], m_flag};
    if (a == 4) return m_dis;
    return 8'h00;
  endfunction

  function automatic logic [7:0] lock_mask(int a);
    if (a == 1) return 8'h0F;
    if (a == 2) return 8'hB7;
    return 8'hFF;
  endfunction

  task automatic xfer(input logic [15:0] f, input int edges, output logic [7:0] got);
    got  = 8'h00;
    cs_n = 1'b0;
    #HP;
    for (int i = 0; i < edges; i++) begin
      mosi = (i < 16) ? f[15-i] : 1'b0;
      #HP;
      if (i >= 8 && i < 16) got = {got[6:0], miso};
      sclk = 1'b1;
      #HP;
      sclk = 1'b0;
    end
    #HP;
    cs_n = 1'b1;
    mosi = 1'b0;
    #(4*HP);
    check8("R2", "miso idle", {7'd0, miso}, 8'h00);
  endtask

  task automatic wr(int a, logic [7:0] d);
    logic [7:0] got;
    xfer({1'b0, 7'(a), d}, 16, got);
    check8("R2", "miso during write", got, 8'h00);
    if (a < 3) m_ctrl[a] = d & lock_mask(a);
    else if (a == 3) m_flag = m_flag & ~d[4:0];
    else if (a == 4) m_dis = d;
    else if (!m_dis[1]) m_flag[1] = 1'b1;
  endtask

  task automatic rd(int a, string req);
    logic [7:0] got;
    xfer({1'b1, 7'(a), 8'h00}, 16, got);
    check8(req, $sformatf("read addr %02h", a), got, m_view(a));
    if (a > 4 && !m_dis[1]) m_flag[1] = 1'b1;
  endtask

  task automatic bad(int edges, int a, logic [7:0] d);
    logic [7:0] got;
    xfer({1'b0, 7'(a), d}, edges, got);
    if (!m_dis[0]) m_flag[0] = 1'b1;
  endtask

  task automatic pulse(int which);
    @(negedge clk);
    case (which)
      2: crc_p = 1'b1;
      3: mm_p  = 1'b1;
      default: rom_p = 1'b1;
    endcase
    @(negedge clk);
    crc_p = 1'b0; mm_p = 1'b0; rom_p = 1'b0;
    if (!m_dis[which]) m_flag[which] = 1'b1;
    #(2*HP);
  endtask

  initial begin
    #1_500_000;
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 3; k++) m_ctrl[k] = 8'h00;
    m_flag = '0;
    m_dis  = 8'h00;
    #100;
    rst_ni = 1'b1;
    #(2*HP);
    // R4 reset state, R1 frame decode
    for (int a = 0; a < 5; a++) rd(a, "R4");
    // R3 masks with several patterns
    for (int a = 0; a < 3; a++) begin
      wr(a, 8'hFF); rd(a, "R3");
      wr(a, 8'hA5); rd(a, "R3");
      wr(a, 8'h5A); rd(a, "R3");
    end
    wr(4, 8'hC0); rd(4, "R3");
    wr(4, 8'h00); rd(4, "R3");
    // R5 short and long frames discard and flag
    wr(0, 8'h3C);
    bad(12, 0, 8'h11); rd(0, "R5"); rd(3, "R5");
    wr(3, 8'h01); rd(3, "R8");
    bad(20, 1, 8'h07); rd(1, "R5"); rd(3, "R5");
    // R8 writing zero keeps, writing one clears
    wr(3, 8'h00); rd(3, "R8");
    wr(3, 8'hFF); rd(3, "R8");
    // R6 unmapped read and write
    rd(7'h40, "R6"); rd(3, "R6");
    wr(3, 8'h02);
    wr(7'h10, 8'hEE); rd(3, "R6");
    for (int a = 0; a < 3; a++) rd(a, "R6");
    wr(3, 8'h1F);
    // R7 status pulses
    pulse(2); rd(3, "R7");
    pulse(3); rd(3, "R7");
    pulse(4); rd(3, "R7");
    wr(3, 8'h1C); rd(3, "R7");
    // R9 disables block setting
    wr(4, 8'h1F);
    pulse(2); pulse(3); pulse(4);
    bad(9, 0, 8'h00);
    rd(7'h7F, "R9");
    rd(3, "R9");
    wr(4, 8'h00);
    // R10 live busy view and its mask
    busy = 1'b1; #HP; rd(3, "R10");
    wr(3, 8'h20); rd(3, "R10");
    wr(4, 8'h20); rd(3, "R10");
    wr(4, 8'h00); busy = 1'b0; #HP; rd(3, "R10");
    // R4 asynchronous reset mid-run
    wr(0, 8'h99);
    #33; rst_ni = 1'b0; #47; rst_ni = 1'b1; #(2*HP);
    for (int k = 0; k < 3; k++) m_ctrl[k] = 8'h00;
    m_flag = '0; m_dis = 8'h00;
    for (int a = 0; a < 5; a++) rd(a, "R4");
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule